// File: doc/BRIEF.md
# Word Memory Responder with Reservation Tracking

This block is a bus target backed by a small word array. A requester presents a command on a request/grant handshake: address, write flag, byte-lane mask, write data, a transaction tag and a six-bit atomic code. The block takes the command in the cycle where the request and the grant are both high. It performs the read, or the byte-masked write, at once. It then returns one response on a valid/ready handshake. The response carries read data, an error flag, an exclusive-success flag and the tag of the command it answers.

The block holds one response at a time. While a response is pending, the grant stays low. The gap between taking a command and raising the response is set per command by a latency input. Addresses outside a window of DEPTH words starting at BASE give an error response. For exclusive accesses, the atomic code is decoded only far enough to recognise load-reserved and store-conditional operations. A one-entry reservation register decides whether a store-conditional may write. Odd parity bits go out next to the grant and the response valid.

Top module: `bus_mem_responder`

## Requirements
- R1: cmdGrant is high exactly when no response is pending. A command is taken at a rising edge where cmdReq and cmdGrant are both high. cmdGrant is low from the cycle after that edge until the cycle after the response handshake, so at most one command is outstanding.
- R2: If a command is taken at edge k with cfgLatency = L sampled at that edge, rspValid is first high in the cycle after edge k+L.
- R3: While rspValid is high and rspReady is low, rspValid stays high and rspTag, rspErr, rspExcl and rspData hold their values. The response is released at the edge where both rspValid and rspReady are high.
- R4: rspTag equals the cmdTag of the command being answered.
- R5: A read in the window returns the stored word. A write stores cmdWdata byte lane b (bits 8b+7 to 8b) only where cmdByteEn bit b is 1, and leaves the other lanes unchanged.
- R6: An address below BASE, or at or above BASE + DEPTH*DATA_W/8, gives rspErr = 1. Such a write changes no memory, and such a read returns zero data.
- R7: A read with cmdAtomic = 6'h22 (load-reserved) in the window reports rspExcl = 1 and records that word in the reservation. Out of the window, it reports rspExcl = 0 and records nothing.
- R8: A write with cmdAtomic = 6'h23 (store-conditional) writes and reports rspExcl = 1 only if a reservation is held for the same word. Otherwise it writes nothing and reports rspExcl = 0. Every store-conditional clears the reservation, and so does reset.
- R9: Any other atomic code, and the load-reserved or store-conditional codes used with the opposite direction, are treated as plain accesses with rspExcl = 0.
- R10: The bit count of {cmdGrant, grantParity} is odd, and so is the bit count of {rspValid, rspValidParity}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLatency | input | LAT_W | Wait cycles before the response, sampled when a command is taken |
| cmdReq | input | 1 | Command present |
| cmdGrant | output | 1 | Block can take a command |
| grantParity | output | 1 | Odd parity companion of cmdGrant |
| cmdAddr | input | ADDR_W | Byte address |
| cmdWrite | input | 1 | 1 for write, 0 for read |
| cmdByteEn | input | DATA_W/8 | Byte lane mask for writes |
| cmdWdata | input | DATA_W | Write data |
| cmdTag | input | TAG_W | Transaction tag |
| cmdAtomic | input | 6 | Atomic code; 6'h22 load-reserved, 6'h23 store-conditional |
| rspValid | output | 1 | Response present |
| rspValidParity | output | 1 | Odd parity companion of rspValid |
| rspReady | input | 1 | Requester takes the response |
| rspData | output | DATA_W | Read data |
| rspErr | output | 1 | Address outside the window |
| rspExcl | output | 1 | Exclusive access succeeded |
| rspTag | output | TAG_W | Tag echoed from the command |

## Verification
The response handshake and the arrival of the next command can fall in the same cycle. A requester that streams commands keeps cmdReq high while it accepts the previous response. The bench provokes this with a load-reserved answered at zero latency. It raises rspReady together with a request for a store-conditional to the same word. It then judges three things: the grant is still low in that cycle, the new command is taken only at the edge after the handshake, and the store-conditional still sees the reservation that the load-reserved just set.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam logic [5:0] ATOMIC_LOAD_RSV  = 6'h22;
  localparam logic [5:0] ATOMIC_STORE_CND = 6'h23;

  typedef struct packed {
    logic accept;    // command taken this cycle
    logic memWrite;  // commit merged word to memory
    logic resvSet;   // record reservation for current word
    logic resvClr;   // drop reservation
  } bmrStrobe_t;
endpackage

// File: rtl/bmr_datapath.sv
module bmr_datapath
  import bmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int BASE   = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  bmrStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W/8-1:0] cmdByteEn,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic              inRange,
  output logic              resvHit,
  output logic [DATA_W-1:0] rspData
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W:0]   RANGE_LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0]   RANGE_HI = (ADDR_W+1)'(BASE + DEPTH * BYTES);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rdQ;
  logic              resvValid;
  logic [IDX_W-1:0]  resvIdx;

  assign inRange = ({1'b0, cmdAddr} >= RANGE_LO) && ({1'b0, cmdAddr} < RANGE_HI);
  assign wordIdx = IDX_W'((cmdAddr - BASE_A) >> OFF_W);
  assign resvHit = resvValid && (resvIdx == wordIdx);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign merged[b*8 +: 8] = cmdByteEn[b] ? cmdWdata[b*8 +: 8] : mem[wordIdx][b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.memWrite) begin
      mem[wordIdx] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strobe.accept) begin
      rdQ <= inRange ? mem[wordIdx] : '0;
    end
  end
  assign rspData = rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      resvIdx   <= '0;
    end else if (strobe.resvClr) begin
      resvValid <= 1'b0;
    end else if (strobe.resvSet) begin
      resvValid <= 1'b1;
      resvIdx   <= wordIdx;
    end
  end

  // R6: memory is only written for a taken command inside the window
  a_r6_write_in_window: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWrite |-> (strobe.accept && inRange));
  // R8: a reservation is never set and cleared by the same command
  a_r8_resv_set_clr: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.resvSet && strobe.resvClr));
endmodule

// File: rtl/bmr_ctrl.sv
module bmr_ctrl
  import bmr_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LAT_W-1:0] cfgLatency,
  input  logic             cmdReq,
  input  logic             cmdWrite,
  input  logic [5:0]       cmdAtomic,
  input  logic [TAG_W-1:0] cmdTag,
  input  logic             rspReady,
  input  logic             inRange,
  input  logic             resvHit,
  output logic             cmdGrant,
  output logic             rspValid,
  output logic [TAG_W-1:0] rspTag,
  output logic             rspErr,
  output logic             rspExcl,
  output bmrStrobe_t       strobe
);
  logic             pending;
  logic [LAT_W-1:0] waitCnt;
  logic             accept;
  logic             isLoadRsv;
  logic             isStoreCnd;
  logic             exclNext;

  assign accept     = cmdReq && !pending;
  assign isLoadRsv  = (cmdAtomic == ATOMIC_LOAD_RSV) && !cmdWrite;
  assign isStoreCnd = (cmdAtomic == ATOMIC_STORE_CND) && cmdWrite;
  assign exclNext   = inRange && (isLoadRsv || (isStoreCnd && resvHit));

  always_comb begin
    strobe.accept   = accept;
    strobe.memWrite = accept && cmdWrite && inRange && (!isStoreCnd || resvHit);
    strobe.resvSet  = accept && isLoadRsv && inRange;
    strobe.resvClr  = accept && isStoreCnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      waitCnt <= '0;
      rspTag  <= '0;
      rspErr  <= 1'b0;
      rspExcl <= 1'b0;
    end else if (accept) begin
      pending <= 1'b1;
      waitCnt <= cfgLatency;
      rspTag  <= cmdTag;
      rspErr  <= !inRange;
      rspExcl <= exclNext;
    end else if (pending) begin
      if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      else if (rspReady) pending <= 1'b0;
    end
  end

  assign cmdGrant = !pending;
  assign rspValid = pending && (waitCnt == '0);

  // R1: never offering a grant while a response is presented
  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdGrant && rspValid));
  // R2: zero latency answers in the next cycle, nonzero latency does not
  a_r2_latency_zero: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cfgLatency == '0) |=> rspValid);
  a_r2_latency_wait: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cfgLatency != '0) |=> !rspValid);
  // R3: a stalled response is held
  a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspTag) && $stable(rspErr) && $stable(rspExcl)));
  // R7: exclusive success never accompanies an error
  a_r7_excl_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspExcl) |-> !rspErr);
endmodule

// File: rtl/bus_mem_responder.sv
module bus_mem_responder
  import bmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,   // 32 or 64
  parameter int DEPTH  = 16,   // words, power of two
  parameter int BASE   = 256,  // first byte address of the window
  parameter int TAG_W  = 4,
  parameter int LAT_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LAT_W-1:0]    cfgLatency,
  input  logic                cmdReq,
  output logic                cmdGrant,
  output logic                grantParity,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic                cmdWrite,
  input  logic [DATA_W/8-1:0] cmdByteEn,
  input  logic [DATA_W-1:0]   cmdWdata,
  input  logic [TAG_W-1:0]    cmdTag,
  input  logic [5:0]          cmdAtomic,
  output logic                rspValid,
  output logic                rspValidParity,
  input  logic                rspReady,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspErr,
  output logic                rspExcl,
  output logic [TAG_W-1:0]    rspTag
);
  bmrStrobe_t strobe;
  logic       inRange;
  logic       resvHit;

  bmr_ctrl #(.TAG_W(TAG_W), .LAT_W(LAT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgLatency(cfgLatency), .cmdReq(cmdReq),
    .cmdWrite(cmdWrite), .cmdAtomic(cmdAtomic), .cmdTag(cmdTag),
    .rspReady(rspReady), .inRange(inRange), .resvHit(resvHit),
    .cmdGrant(cmdGrant), .rspValid(rspValid), .rspTag(rspTag),
    .rspErr(rspErr), .rspExcl(rspExcl), .strobe(strobe)
  );

  bmr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BASE(BASE)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdByteEn(cmdByteEn), .cmdWdata(cmdWdata), .inRange(inRange),
    .resvHit(resvHit), .rspData(rspData)
  );

  assign grantParity    = ~cmdGrant;
  assign rspValidParity = ~rspValid;
endmodule

// File: tb/bus_mem_responder_tb_top.sv
`timescale 1ns/1ps
module bus_mem_responder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgLatency = '0;
  logic        cmdReq = 1'b0;
  logic        cmdGrant, grantParity;
  logic [11:0] cmdAddr = '0;
  logic        cmdWrite = 1'b0;
  logic [3:0]  cmdByteEn = '0;
  logic [31:0] cmdWdata = '0;
  logic [3:0]  cmdTag = '0;
  logic [5:0]  cmdAtomic = '0;
  logic        rspValid, rspValidParity;
  logic        rspReady = 1'b0;
  logic [31:0] rspData;
  logic        rspErr, rspExcl;
  logic [3:0]  rspTag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_mem_responder dut_i (
    .clk(clk), .rstN(rstN), .cfgLatency(cfgLatency), .cmdReq(cmdReq),
    .cmdGrant(cmdGrant), .grantParity(grantParity), .cmdAddr(cmdAddr),
    .cmdWrite(cmdWrite), .cmdByteEn(cmdByteEn), .cmdWdata(cmdWdata),
    .cmdTag(cmdTag), .cmdAtomic(cmdAtomic), .rspValid(rspValid),
    .rspValidParity(rspValidParity), .rspReady(rspReady), .rspData(rspData),
    .rspErr(rspErr), .rspExcl(rspExcl), .rspTag(rspTag)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [5:0]  at;
    logic [3:0]  tg;
    logic [3:0]  lat;
    logic [1:0]  rdy;
    logic        eErr;
    logic        eExcl;
    logic        chkD;
    logic [31:0] eData;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h100, 4'hF, 32'h11223344, 6'h00, 4'h1, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h100, 4'hF, 32'h0,        6'h00, 4'h2, 4'd2, 2'd1, 1'b0, 1'b0, 1'b1, 32'h11223344},
    '{1'b1, 12'h100, 4'h5, 32'hAABBCCDD, 6'h00, 4'h3, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h100, 4'hF, 32'h0,        6'h00, 4'h4, 4'd1, 2'd2, 1'b0, 1'b0, 1'b1, 32'h11BB33DD},
    '{1'b1, 12'h200, 4'hF, 32'hFFFFFFFF, 6'h00, 4'h5, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h200, 4'hF, 32'h0,        6'h00, 4'h6, 4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0},
    '{1'b1, 12'h13C, 4'hF, 32'h5A5A5A5A, 6'h00, 4'h7, 4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h13C, 4'hF, 32'h0,        6'h00, 4'h8, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h5A5A5A5A},
    '{1'b0, 12'h140, 4'hF, 32'h0,        6'h00, 4'h9, 4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0},
    '{1'b0, 12'h0FC, 4'hF, 32'h0,        6'h00, 4'hA, 4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0},
    '{1'b0, 12'h104, 4'hF, 32'h0,        6'h22, 4'hB, 4'd0, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0},
    '{1'b1, 12'h104, 4'hF, 32'h12345678, 6'h23, 4'hC, 4'd1, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0},
    '{1'b0, 12'h104, 4'hF, 32'h0,        6'h00, 4'hD, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h12345678},
    '{1'b1, 12'h104, 4'hF, 32'h0,        6'h23, 4'hE, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h104, 4'hF, 32'h0,        6'h00, 4'hF, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h12345678},
    '{1'b0, 12'h108, 4'hF, 32'h0,        6'h22, 4'h0, 4'd0, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0},
    '{1'b1, 12'h10C, 4'hF, 32'h9,        6'h23, 4'h1, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h10C, 4'hF, 32'h0,        6'h00, 4'h2, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0},
    '{1'b1, 12'h108, 4'hF, 32'h77,       6'h23, 4'h3, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h108, 4'hF, 32'h0,        6'h00, 4'h4, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0},
    '{1'b0, 12'h100, 4'hF, 32'h0,        6'h02, 4'h5, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h11BB33DD},
    '{1'b0, 12'h100, 4'hF, 32'h0,        6'h23, 4'h6, 4'd2, 2'd0, 1'b0, 1'b0, 1'b1, 32'h11BB33DD},
    '{1'b0, 12'h200, 4'hF, 32'h0,        6'h22, 4'h7, 4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0},
    '{1'b1, 12'h100, 4'hF, 32'hDEADBEEF, 6'h22, 4'h8, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h100, 4'hF, 32'h0,        6'h00, 4'h9, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'hDEADBEEF},
    '{1'b1, 12'h100, 4'hF, 32'h1,        6'h23, 4'hA, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b0, 12'h100, 4'hF, 32'h0,        6'h00, 4'hB, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'hDEADBEEF}
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cmdWrite = v.we; cmdAddr = v.addr; cmdByteEn = v.be; cmdWdata = v.wd;
    cmdAtomic = v.at; cmdTag = v.tg; cfgLatency = v.lat; cmdReq = 1'b1;
  endtask

  task automatic runTxn(input vec_t v);
    int waited;
    @(negedge clk);
    chk(cmdGrant, 1, "R1 grant while idle");
    chk(grantParity, 0, "R10 grant parity idle");
    drive(v);
    @(negedge clk);
    cmdReq = 1'b0;
    chk(cmdGrant, 0, "R1 grant low after accept");
    chk(grantParity, 1, "R10 grant parity busy");
    waited = 0;
    while (!rspValid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    chk(waited, v.lat, "R2 latency to rspValid");
    chk(rspValidParity, 0, "R10 valid parity");
    for (int i = 0; i < v.rdy; i++) begin
      @(negedge clk);
      chk(rspValid, 1, "R3 valid held while stalled");
    end
    chk(rspTag, v.tg, "R4 tag echo");
    chk(rspErr, v.eErr, "R6 range error");
    chk(rspExcl, v.eExcl, "R7 R8 R9 exclusive flag");
    if (v.chkD) chk(rspData, v.eData, "R5 R6 read data");
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(rspValid, 0, "R3 released after handshake");
    chk(cmdGrant, 1, "R1 grant back after handshake");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // reset state (R1, R10)
    chk(cmdGrant, 1, "R1 reset grant");
    chk(rspValid, 0, "R1 reset no response");
    chk(grantParity, 0, "R10 reset grant parity");
    chk(rspValidParity, 1, "R10 reset valid parity");
    rstN = 1'b1;

    for (int n = 0; n < NV; n++) runTxn(VECS[n]);

    // R8: reservation survives a plain read of the same word
    runTxn('{1'b0, 12'h110, 4'hF, 32'h0, 6'h22, 4'h1, 4'd0, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0});
    runTxn('{1'b0, 12'h110, 4'hF, 32'h0, 6'h00, 4'h2, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0});
    runTxn('{1'b1, 12'h110, 4'hF, 32'h55, 6'h23, 4'h3, 4'd0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0});

    // R1 R8: handshake and next request in the same cycle
    @(negedge clk);
    drive('{1'b0, 12'h114, 4'hF, 32'h0, 6'h22, 4'h4, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0});
    @(negedge clk);
    chk(rspValid, 1, "R2 zero latency response");
    drive('{1'b1, 12'h114, 4'hF, 32'h66, 6'h23, 4'h5, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0});
    rspReady = 1'b1;
    chk(cmdGrant, 0, "R1 no grant during handshake cycle");
    chk(rspTag, 4, "R4 tag of load-reserved");
    @(negedge clk);
    rspReady = 1'b0;
    chk(rspValid, 0, "R1 response gone after handshake");
    chk(cmdGrant, 1, "R1 grant returns with request held");
    @(negedge clk);
    cmdReq = 1'b0;
    chk(rspValid, 1, "R2 queued request answered");
    chk(rspTag, 5, "R4 tag of store-conditional");
    chk(rspExcl, 1, "R8 store-conditional after back-to-back reserve");
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    runTxn('{1'b0, 12'h114, 4'hF, 32'h0, 6'h00, 4'h6, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h66});

    // R8: reset clears the reservation
    runTxn('{1'b0, 12'h118, 4'hF, 32'h0, 6'h22, 4'h7, 4'd0, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0});
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    v = '{1'b1, 12'h118, 4'hF, 32'h99, 6'h23, 4'h8, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0};
    runTxn(v);
    runTxn('{1'b0, 12'h118, 4'hF, 32'h0, 6'h00, 4'h9, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule